// File: doc/BRIEF.md
# Paired Micro-Op Atomic Retirement Controller

This block is the retirement side of an in-order window that holds 64-bit micro-operations. An architectural 128-bit operation enters the window as two adjacent entries. The first entry carries a hold marker, and the two halves complete independently through the writeback ports. Each cycle the controller looks at the two oldest entries and decides how many of them commit: none, one or two. A marked entry never commits without its partner. Because of this, a 128-bit destination is never written by one half when the other half has faulted.

An exception counts as unmasked when a flag is raised in a class whose bit in `exc_mask` is 0. An unmasked exception from either half of a held pair makes the controller pulse an exception request carrying the index of the first half, and it clears the whole window at the same moment. When every class is masked, the hold is bypassed and each entry commits as soon as it is oldest and complete. Exception flags of committed entries accumulate in sticky status bits.

The control is a two-state machine:
- `ST_RUN` is the normal allocate, complete and commit state.
- `ST_TRAP` is a one-cycle state that drives the exception request while the window is empty.

Transitions:
- `ST_RUN`→`ST_TRAP` when the oldest entry or pair shows an unmasked fault.
- `ST_TRAP`→`ST_RUN` always on the next cycle.
- Any state→`ST_RUN` on `flush`.

`DEPTH` must be a power of two.

Top module: `retire_pair_ctrl`

## Requirements
- R1: After reset the window is empty, `alloc_ready`=1, `alloc_idx`=0, `commit_cnt`=0, `exc_req`=0 and `sticky_flags`=0.
- R2: An accepted allocation with `alloc_pair`=1 fills two consecutive indices starting at `alloc_idx`, and marks the first of them. With `alloc_pair`=0 it fills one unmarked entry. `alloc_ready` is 0 when fewer than two entries are free.
- R3: Unless every mask bit is 1, a marked entry at the head does not commit while its partner has not completed, even if the marked entry itself has completed cleanly.
- R4: A held pair whose halves have both completed without unmasked exceptions commits in a single cycle, with `commit_cnt`=2 and `commit_idx` equal to the first half.
- R5: If either half of a held pair shows an unmasked flag (flag bit 1 while the same `exc_mask` bit is 0), neither half commits. One cycle later `exc_req` is 1 for exactly one cycle, with `exc_idx` equal to the first half, and `alloc_ready`=0 in that cycle. After that the window is empty and allocation restarts at index 0.
- R6: When `exc_mask` is all ones, the marker is ignored. A completed first half commits alone with `commit_cnt`=1.
- R7: Unmarked entries commit in program order, up to two per cycle. A completed entry behind an incomplete older one does not commit.
- R8: `sticky_flags` ORs in the flag bits of an entry only in the cycle after that entry commits. Flags of a faulting pair never reach it.
- R9: `flush` empties the window. On the next cycle `alloc_ready`=1 and `alloc_idx`=0, and a writeback to an index that is not currently allocated has no effect on commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Clears every window entry |
| exc_mask | input | FLAGS | One bit per exception class, 1 = masked |
| alloc_valid | input | 1 | Allocation request |
| alloc_pair | input | 1 | Request is a 128-bit pair (two entries) |
| alloc_ready | output | 1 | Allocation can be accepted this cycle |
| alloc_idx | output | PW | Index given to the (first) new entry |
| wb_valid | input | NWB | Completion strobe per writeback port |
| wb_idx | input | NWB*PW | Completed entry index per port |
| wb_exc | input | NWB*FLAGS | Exception flags per port |
| commit_cnt | output | 2 | Number of entries committing this cycle |
| commit_idx | output | PW | Index of the oldest committing entry |
| sticky_flags | output | FLAGS | Accumulated flags of committed entries |
| exc_req | output | 1 | Exception request pulse |
| exc_idx | output | PW | Entry index that caused the request |

## Verification
Suppose the hold marker were lost or the pair check were wrong. The bench would then see `commit_cnt`=1 with a marked entry at the head in the very cycle the first half completes, before its partner has completed. A stale head or tail pointer would show up one allocation later as a wrong `alloc_idx`, and a wrong entry count would show up as `alloc_ready` holding high on a full window. A fault that is missed or reported at the wrong entry appears at the ports one cycle after both halves complete: either `exc_req` stays low and a commit happens instead, or `exc_idx` carries the wrong entry. Sticky corruption appears one cycle after the commit that should, or should not, have set the bits.

// File: rtl/retire_pkg.sv
package retire_pkg;
    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_TRAP = 1'b1
    } rstate_e;
endpackage

// File: rtl/retire_entries.sv
module retire_entries #(
    parameter int DEPTH = 8,
    parameter int FLAGS = 4,
    parameter int NWB   = 2,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic                        alloc_we,
    input  logic                        alloc_pair,
    input  logic [PW-1:0]               tail,
    input  logic [PW-1:0]               head,
    input  logic [1:0]                  ret_cnt,
    input  logic [NWB-1:0]              wb_valid,
    input  logic [NWB*PW-1:0]           wb_idx,
    input  logic [NWB*FLAGS-1:0]        wb_exc,
    output logic [DEPTH-1:0]            ent_v,
    output logic [DEPTH-1:0]            ent_d,
    output logic [DEPTH-1:0]            ent_m,
    output logic [DEPTH-1:0][FLAGS-1:0] ent_exc
);
    logic [PW-1:0] head1, tail1;
    assign head1 = head + 1'b1;
    assign tail1 = tail + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ent_v   <= '0;
            ent_d   <= '0;
            ent_m   <= '0;
            ent_exc <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                // retirement frees the oldest one or two slots
                if (ret_cnt != 2'd0 && PW'(i) == head) ent_v[i] <= 1'b0;
                if (ret_cnt == 2'd2 && PW'(i) == head1) ent_v[i] <= 1'b0;
                // completion only lands on live entries
                for (int w = 0; w < NWB; w++) begin
                    if (wb_valid[w] && wb_idx[w*PW +: PW] == PW'(i) && ent_v[i]) begin
                        ent_d[i]   <= 1'b1;
                        ent_exc[i] <= wb_exc[w*FLAGS +: FLAGS];
                    end
                end
                if (alloc_we && PW'(i) == tail) begin
                    ent_v[i]   <= 1'b1;
                    ent_d[i]   <= 1'b0;
                    ent_m[i]   <= alloc_pair;
                    ent_exc[i] <= '0;
                end
                if (alloc_we && alloc_pair && PW'(i) == tail1) begin
                    ent_v[i]   <= 1'b1;
                    ent_d[i]   <= 1'b0;
                    ent_m[i]   <= 1'b0;
                    ent_exc[i] <= '0;
                end
            end
        end
    end

    AST_DONE_NEEDS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_cnt != 2'd0) |-> (ent_v[head] && ent_d[head])); // R7
endmodule

// File: rtl/retire_select.sv
module retire_select #(
    parameter int DEPTH = 8,
    parameter int FLAGS = 4,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic [PW-1:0]               head,
    input  logic [DEPTH-1:0]            ent_v,
    input  logic [DEPTH-1:0]            ent_d,
    input  logic [DEPTH-1:0]            ent_m,
    input  logic [DEPTH-1:0][FLAGS-1:0] ent_exc,
    input  logic [FLAGS-1:0]            exc_mask,
    output logic [1:0]                  ret_cnt,
    output logic                        trap_hit,
    output logic [PW-1:0]               trap_idx
);
    logic [PW-1:0] h1;
    logic          bypass, rdy0, rdy1, bad0, bad1;

    assign h1     = head + 1'b1;
    assign bypass = &exc_mask;
    assign rdy0   = ent_v[head] && ent_d[head];
    assign rdy1   = ent_v[h1] && ent_d[h1];
    assign bad0   = |(ent_exc[head] & ~exc_mask);
    assign bad1   = |(ent_exc[h1] & ~exc_mask);

    always_comb begin
        ret_cnt  = 2'd0;
        trap_hit = 1'b0;
        trap_idx = head;
        if (rdy0) begin
            if (bypass) begin
                ret_cnt = rdy1 ? 2'd2 : 2'd1;
            end else if (ent_m[head]) begin
                if (rdy1) begin
                    if (bad0 || bad1) trap_hit = 1'b1;
                    else              ret_cnt  = 2'd2;
                end
            end else if (bad0) begin
                trap_hit = 1'b1;
            end else if (rdy1 && !ent_m[h1] && !bad1) begin
                ret_cnt = 2'd2;
            end else begin
                ret_cnt = 2'd1;
            end
        end
    end
endmodule

// File: rtl/retire_pair_ctrl.sv
module retire_pair_ctrl
    import retire_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int FLAGS = 4,
    parameter int NWB   = 2,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic [FLAGS-1:0]     exc_mask,
    input  logic                 alloc_valid,
    input  logic                 alloc_pair,
    output logic                 alloc_ready,
    output logic [PW-1:0]        alloc_idx,
    input  logic [NWB-1:0]       wb_valid,
    input  logic [NWB*PW-1:0]    wb_idx,
    input  logic [NWB*FLAGS-1:0] wb_exc,
    output logic [1:0]           commit_cnt,
    output logic [PW-1:0]        commit_idx,
    output logic [FLAGS-1:0]     sticky_flags,
    output logic                 exc_req,
    output logic [PW-1:0]        exc_idx
);
    localparam int CW = PW + 1;

    rstate_e                    state_q, state_d;
    logic [PW-1:0]              head_q, tail_q, exc_idx_q, trap_idx;
    logic [CW-1:0]              count_q;
    logic [FLAGS-1:0]           sticky_q;
    logic [DEPTH-1:0]           ent_v, ent_d, ent_m;
    logic [DEPTH-1:0][FLAGS-1:0] ent_exc;
    logic [1:0]                 sel_cnt, add_cnt;
    logic                       trap_hit, trap_go, alloc_we, clr, run;
    logic [PW-1:0]              head1;

    assign head1 = head_q + 1'b1;

    retire_entries #(.DEPTH(DEPTH), .FLAGS(FLAGS), .NWB(NWB)) u_ent (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .alloc_we(alloc_we), .alloc_pair(alloc_pair),
        .tail(tail_q), .head(head_q), .ret_cnt(commit_cnt),
        .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_exc(wb_exc),
        .ent_v(ent_v), .ent_d(ent_d), .ent_m(ent_m), .ent_exc(ent_exc)
    );

    retire_select #(.DEPTH(DEPTH), .FLAGS(FLAGS)) u_sel (
        .head(head_q), .ent_v(ent_v), .ent_d(ent_d), .ent_m(ent_m),
        .ent_exc(ent_exc), .exc_mask(exc_mask),
        .ret_cnt(sel_cnt), .trap_hit(trap_hit), .trap_idx(trap_idx)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (trap_go) state_d = ST_TRAP;
            ST_TRAP: state_d = ST_RUN;
        endcase
        if (flush) state_d = ST_RUN;
    end

    // outputs and handshakes
    always_comb begin
        run          = (state_q == ST_RUN);
        exc_req      = (state_q == ST_TRAP);
        exc_idx      = exc_idx_q;
        commit_cnt   = (run && !flush) ? sel_cnt : 2'd0;
        commit_idx   = head_q;
        trap_go      = run && trap_hit && !flush;
        alloc_ready  = run && ((CW'(DEPTH) - count_q) >= CW'(2));
        alloc_idx    = tail_q;
        alloc_we     = alloc_valid && alloc_ready && !flush;
        clr          = flush || trap_go;
        add_cnt      = alloc_we ? (alloc_pair ? 2'd2 : 2'd1) : 2'd0;
        sticky_flags = sticky_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q    <= '0;
            tail_q    <= '0;
            count_q   <= '0;
            exc_idx_q <= '0;
            sticky_q  <= '0;
        end else if (clr) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
            if (trap_go) exc_idx_q <= trap_idx;
        end else begin
            head_q  <= head_q + PW'(commit_cnt);
            tail_q  <= tail_q + PW'(add_cnt);
            count_q <= count_q - CW'(commit_cnt) + CW'(add_cnt);
            if (commit_cnt != 2'd0) sticky_q <= sticky_q | ent_exc[head_q]
                | ((commit_cnt == 2'd2) ? ent_exc[head1] : '0);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(DEPTH)); // R2
    AST_HELD_PAIR_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&exc_mask) && ent_m[head_q] && commit_cnt != 2'd0) |-> (commit_cnt == 2'd2)); // R4
    AST_HOLD_PARTNER: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&exc_mask) && ent_m[head_q] && !ent_d[head1]) |-> (commit_cnt == 2'd0)); // R3
    AST_TRAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |=> !exc_req); // R5
    AST_TRAP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> (count_q == '0 && commit_cnt == 2'd0)); // R5
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count_q == '0 && !exc_req)); // R9
    AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((sticky_q & $past(sticky_q)) == $past(sticky_q))); // R8
endmodule

// File: tb/retire_pair_ctrl_tb.sv
module retire_pair_ctrl_tb;
    localparam int DEPTH = 8, FLAGS = 4, NWB = 2, PW = 3;

    logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
    logic [FLAGS-1:0] exc_mask = '0;
    logic alloc_valid = 1'b0, alloc_pair = 1'b0;
    logic alloc_ready;
    logic [PW-1:0] alloc_idx, commit_idx, exc_idx;
    logic [NWB-1:0] wb_valid = '0;
    logic [NWB*PW-1:0] wb_idx = '0;
    logic [NWB*FLAGS-1:0] wb_exc = '0;
    logic [1:0] commit_cnt;
    logic [FLAGS-1:0] sticky_flags;
    logic exc_req;
    int total = 0, bad = 0;

    always #4 clk = ~clk;

    retire_pair_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .exc_mask(exc_mask),
        .alloc_valid(alloc_valid), .alloc_pair(alloc_pair),
        .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
        .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_exc(wb_exc),
        .commit_cnt(commit_cnt), .commit_idx(commit_idx),
        .sticky_flags(sticky_flags), .exc_req(exc_req), .exc_idx(exc_idx)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic alloc(input logic pair, input int exp_idx, input string req);
        chk(req, int'(alloc_idx), exp_idx);
        alloc_valid = 1'b1;
        alloc_pair  = pair;
        step();
        alloc_valid = 1'b0;
        alloc_pair  = 1'b0;
    endtask

    task automatic wb2(input logic v0, input int i0, input int f0,
                       input logic v1, input int i1, input int f1);
        wb_valid = {v1, v0};
        wb_idx   = {PW'(i1), PW'(i0)};
        wb_exc   = {FLAGS'(f1), FLAGS'(f0)};
        step();
        wb_valid = '0;
    endtask

    task automatic t_reset();
        step(); step();
        rst_n = 1'b1;
        step();
        chk("R1 alloc_ready", int'(alloc_ready), 1);
        chk("R1 alloc_idx", int'(alloc_idx), 0);
        chk("R1 commit_cnt", int'(commit_cnt), 0);
        chk("R1 exc_req", int'(exc_req), 0);
        chk("R1 sticky", int'(sticky_flags), 0);
    endtask

    task automatic t_pair_clean();
        alloc(1'b1, 0, "R2 pair idx");
        wb2(1, 0, 0, 0, 0, 0);
        chk("R3 hold first half", int'(commit_cnt), 0);
        wb2(0, 0, 0, 1, 1, 0);
        chk("R4 pair together cnt", int'(commit_cnt), 2);
        chk("R4 pair together idx", int'(commit_idx), 0);
        step();
        chk("R4 after commit cnt", int'(commit_cnt), 0);
        chk("R2 next idx after pair", int'(alloc_idx), 2);
    endtask

    task automatic t_bypass();
        exc_mask = 4'hF;
        alloc(1'b1, 2, "R2 pair idx");
        wb2(1, 2, 4'b0001, 0, 0, 0);
        chk("R6 first half alone", int'(commit_cnt), 1);
        chk("R6 commit idx", int'(commit_idx), 2);
        chk("R8 sticky before commit", int'(sticky_flags), 0);
        step();
        chk("R8 sticky after commit", int'(sticky_flags), 1);
        wb2(1, 3, 0, 0, 0, 0);
        chk("R6 second half alone", int'(commit_cnt), 1);
        chk("R6 second idx", int'(commit_idx), 3);
        step();
        exc_mask = 4'h0;
    endtask

    task automatic t_fault();
        alloc(1'b1, 4, "R2 pair idx");
        wb2(1, 4, 0, 1, 5, 4'b0010);
        chk("R5 no commit on fault", int'(commit_cnt), 0);
        chk("R5 req not yet", int'(exc_req), 0);
        step();
        chk("R5 exc_req", int'(exc_req), 1);
        chk("R5 exc_idx first half", int'(exc_idx), 4);
        chk("R5 alloc blocked", int'(alloc_ready), 0);
        chk("R8 fault flags kept out", int'(sticky_flags), 1);
        step();
        chk("R5 req one cycle", int'(exc_req), 0);
        chk("R5 ready again", int'(alloc_ready), 1);
        chk("R5 window cleared", int'(alloc_idx), 0);
    endtask

    task automatic t_singles();
        alloc(1'b0, 0, "R2 single idx");
        alloc(1'b0, 1, "R2 single idx");
        alloc(1'b0, 2, "R2 single idx");
        wb2(1, 1, 0, 0, 0, 0);
        chk("R7 younger waits", int'(commit_cnt), 0);
        wb2(1, 0, 0, 0, 0, 0);
        chk("R7 two singles", int'(commit_cnt), 2);
        chk("R7 oldest idx", int'(commit_idx), 0);
        step();
        wb2(1, 2, 0, 0, 0, 0);
        chk("R7 third single", int'(commit_cnt), 1);
        chk("R7 third idx", int'(commit_idx), 2);
        step();
        chk("R2 tail after singles", int'(alloc_idx), 3);
    endtask

    task automatic t_full_flush();
        alloc(1'b1, 3, "R2 fill");
        alloc(1'b1, 5, "R2 fill");
        alloc(1'b1, 7, "R2 fill wrap");
        chk("R2 ready with two free", int'(alloc_ready), 1);
        alloc(1'b1, 1, "R2 fill last");
        chk("R2 ready low when full", int'(alloc_ready), 0);
        flush = 1'b1;
        step();
        flush = 1'b0;
        chk("R9 ready after flush", int'(alloc_ready), 1);
        chk("R9 idx after flush", int'(alloc_idx), 0);
        alloc(1'b0, 0, "R9 single after flush");
        wb2(1, 5, 0, 0, 0, 0);
        chk("R9 stale writeback ignored", int'(commit_cnt), 0);
        wb2(1, 0, 0, 0, 0, 0);
        chk("R9 live entry commits", int'(commit_cnt), 1);
        step();
    endtask

    task automatic t_partial_mask();
        exc_mask = 4'b1010;
        alloc(1'b1, 1, "R2 pair idx");
        wb2(1, 1, 4'b0010, 0, 0, 0);
        chk("R3 hold under partial mask", int'(commit_cnt), 0);
        wb2(1, 2, 4'b1000, 0, 0, 0);
        chk("R4 masked flags pair commits", int'(commit_cnt), 2);
        chk("R4 pair idx", int'(commit_idx), 1);
        step();
        chk("R8 sticky accumulates", int'(sticky_flags), 4'b1011);
        exc_mask = 4'h0;
    endtask

    initial begin
        t_reset();
        t_pair_clean();
        t_bypass();
        t_fault();
        t_singles();
        t_full_flush();
        t_partial_mask();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule